// File: doc/BRIEF.md
# I2C Controller Register Block

This block is the software-visible face of an I2C master engine. It decodes a simple word-addressed register bus and holds the engine's configuration: the core enable, the bus speed select, two FIFO threshold fields and three SCL and SDA timing counts. A write to the command port passes a 10-bit command word straight to the engine's command FIFO. A read of the receive data port pops one byte from the receive FIFO. The FIFO levels and the engine's busy flag are read-only views of inputs.

The block drives one interrupt line. Two readiness conditions are derived every cycle by comparing the FIFO levels against the threshold fields. Three error events (address or data not acknowledged, arbitration lost, receive overflow) are caught as sticky flags that software clears by writing 1. The interrupt is the OR of every status flag that is also set in the interrupt enable register.

Read data is registered: it appears on the cycle after the read strobe and holds until the next read. Reads and writes are expected on separate cycles.

Top module: `i2c_ctl_regs`

## Requirements
- R1: After a synchronous active-low reset, the control, interrupt enable and timing registers and all sticky flags are 0, `irq` is 0 and `bus_rdata` is 0.
- R2: The control word at byte offset 0x08 holds enable in bit 0, fast mode in bit 1, the command threshold in bits 3:2 and the receive threshold in bits 5:4. It reads back with bits 31:6 at 0. `ctl_enable` and `ctl_fast` follow bits 0 and 1.
- R3: Status bit 0 (TX-ready) at offset 0x10 is 1 exactly when `cmd_level` is at or below the command threshold field plus 1.
- R4: Status bit 1 (RX-ready) is 1 exactly when `rx_level` is at or above the receive threshold field plus 1.
- R5: A one-cycle pulse on `evt_nack`, `evt_arb_lost` or `evt_rx_ovf` sets status bit 2, 3 or 4 respectively, and the bit stays set until it is cleared.
- R6: Writing offset 0x10 clears each sticky bit whose data bit is 1 and leaves bits written 0 unchanged. An event in the same cycle as its clear leaves the bit set. Such writes do not alter bits 1:0.
- R7: The interrupt enable register at 0x0C uses the status bit layout (5 bits, reads back with the upper bits at 0). `irq` is 1 exactly when some status bit and its enable bit are both 1.
- R8: A write to offset 0x00 raises `cmd_push` in that same cycle, with `cmd_word` equal to write data bits 9:0.
- R9: A read of offset 0x04 while `rx_level` is nonzero raises `rx_pop` in that cycle and returns `rx_head` in bits 7:0. A read while `rx_level` is 0 raises no pop and returns the last popped byte (0 if none has been popped since reset).
- R10: Offset 0x14 returns `core_busy` in bit 0. Offset 0x18 returns `cmd_level` and offset 0x1C returns `rx_level`, zero-extended.
- R11: Offsets 0x20, 0x24 and 0x28 hold the SCL low, SCL high and SDA hold counts, CNT_W bits each. They drive `scl_low`, `scl_high` and `sda_hold`, and they read back with higher bits at 0.
- R12: `bus_rdata` updates only on the cycle after a read strobe and then holds. Unmapped offsets read 0. Writes to read-only or unmapped offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_rd_en | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| cmd_level | input | LVL_W | Command FIFO fill level |
| rx_level | input | LVL_W | Receive FIFO fill level |
| rx_head | input | 8 | Byte at the head of the receive FIFO |
| core_busy | input | 1 | Engine busy flag |
| evt_nack | input | 1 | Pulse: acknowledge missing |
| evt_arb_lost | input | 1 | Pulse: arbitration lost |
| evt_rx_ovf | input | 1 | Pulse: receive FIFO overflow |
| cmd_push | output | 1 | Push command word into command FIFO |
| cmd_word | output | 10 | Command word (start bit 9, stop bit 8, data 7:0) |
| rx_pop | output | 1 | Pop one byte from receive FIFO |
| ctl_enable | output | 1 | Core enable |
| ctl_fast | output | 1 | Fast bus speed select |
| scl_low | output | CNT_W | SCL low count |
| scl_high | output | CNT_W | SCL high count |
| sda_hold | output | CNT_W | SDA hold count |
| irq | output | 1 | Interrupt request |

## Verification
The bench uses the defaults FIFO_DEPTH = 4 (levels 0 to 4), CNT_W = 16 and ADDR_W = 6. With these values every threshold code can be crossed with every FIFO level for both readiness comparisons, including the full and empty ends. Each of the 32 interrupt enable masks is checked against each of the 32 combinations of sticky and readiness flags. With a 16-bit count width, writes with set upper bits show how the timing registers truncate.

// File: rtl/i2c_ctl_pkg.sv
// Package: register indices, bit positions and the control word layout
// shared by the register block, its submodules and its checker.
package i2c_ctl_pkg;
    localparam int NUM_REGS = 11;
    localparam int IDX_CMD  = 0;   // 0x00 command push port
    localparam int IDX_RXD  = 1;   // 0x04 receive data pop port
    localparam int IDX_CTL  = 2;   // 0x08 control
    localparam int IDX_IE   = 3;   // 0x0C interrupt enable
    localparam int IDX_IS   = 4;   // 0x10 interrupt status
    localparam int IDX_ST   = 5;   // 0x14 core status
    localparam int IDX_CLV  = 6;   // 0x18 command FIFO level
    localparam int IDX_RLV  = 7;   // 0x1C receive FIFO level
    localparam int IDX_TIM0 = 8;   // 0x20..0x28 timing counts
    localparam int NUM_TIM  = 3;

    localparam int IRQ_W    = 5;
    localparam int IRQ_TXR  = 0;
    localparam int IRQ_RXR  = 1;
    localparam int IRQ_ERR0 = 2;   // first sticky bit
    localparam int NUM_ERR  = 3;

    localparam int CMD_W    = 10;
    localparam int CTL_W    = 6;

    typedef struct packed {
        logic [1:0] rx_thr;
        logic [1:0] cmd_thr;
        logic       fast;
        logic       en;
    } ctl_t;
endpackage

// File: rtl/i2c_ctl_decode.sv
// Module: i2c_ctl_decode
// Turns a byte address plus strobes into one-hot register selects.
// Assumes word-aligned addresses; the two low address bits are ignored.
module i2c_ctl_decode #(
    parameter int ADDR_W = 6,
    parameter int NREG   = 11
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    output logic [NREG-1:0]   wr_sel,
    output logic [NREG-1:0]   rd_sel
);
    localparam int IDXW = ADDR_W - 2;

    logic [IDXW-1:0] word_idx;
    logic            unused_lsb;

    assign word_idx   = addr[ADDR_W-1:2];
    assign unused_lsb = ^addr[1:0];

    // One comparator per register for the write and the read select.
    for (genvar i = 0; i < NREG; i++) begin : g_sel
        assign wr_sel[i] = wr && (word_idx == IDXW'(i));
        assign rd_sel[i] = rd && (word_idx == IDXW'(i));
    end
endmodule

// File: rtl/i2c_ctl_cfg.sv
// Module: i2c_ctl_cfg
// Holds the writable configuration: control word, interrupt enable mask
// and the timing counts. Assumes write selects are one-hot.
module i2c_ctl_cfg
    import i2c_ctl_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int NREG  = 11
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NREG-1:0]               wr_sel,
    input  logic [31:0]                   wdata,
    output ctl_t                          ctl_q,
    output logic [IRQ_W-1:0]              ie_q,
    output logic [NUM_TIM-1:0][CNT_W-1:0] tim_q
);
    // Control word register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctl_q <= '0;
        else if (wr_sel[IDX_CTL])
            ctl_q <= ctl_t'(wdata[CTL_W-1:0]);
    end

    // Interrupt enable mask register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ie_q <= '0;
        else if (wr_sel[IDX_IE])
            ie_q <= wdata[IRQ_W-1:0];
    end

    // One register per timing count, at consecutive word indices.
    for (genvar t = 0; t < NUM_TIM; t++) begin : g_tim
        always_ff @(posedge clk) begin
            if (!rst_n)
                tim_q[t] <= '0;
            else if (wr_sel[IDX_TIM0+t])
                tim_q[t] <= wdata[CNT_W-1:0];
        end
    end
endmodule

// File: rtl/i2c_ctl_irq.sv
// Module: i2c_ctl_irq
// Derives the two readiness flags from FIFO levels and thresholds, keeps
// the sticky error flags and forms the interrupt. Threshold code n means
// n+1 elements. An event in the same cycle as its clear wins.
module i2c_ctl_irq
    import i2c_ctl_pkg::*;
#(
    parameter int LVL_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         cmd_thr,
    input  logic [1:0]         rx_thr,
    input  logic [LVL_W-1:0]   cmd_level,
    input  logic [LVL_W-1:0]   rx_level,
    input  logic [NUM_ERR-1:0] evt,
    input  logic               clr_wr,
    input  logic [IRQ_W-1:0]   clr_mask,
    input  logic [IRQ_W-1:0]   ie,
    output logic [IRQ_W-1:0]   status,
    output logic               irq
);
    logic [NUM_ERR-1:0] err_q;
    logic               tx_rdy;
    logic               rx_rdy;

    // Level comparisons against threshold plus one.
    always_comb begin
        tx_rdy = int'(cmd_level) <= (int'(cmd_thr) + 1);
        rx_rdy = int'(rx_level)  >= (int'(rx_thr) + 1);
    end

    // Sticky error flags, one per event input.
    for (genvar e = 0; e < NUM_ERR; e++) begin : g_err
        always_ff @(posedge clk) begin
            if (!rst_n)
                err_q[e] <= 1'b0;
            else if (evt[e])
                err_q[e] <= 1'b1;
            else if (clr_wr && clr_mask[IRQ_ERR0+e])
                err_q[e] <= 1'b0;
        end
    end

    // Status layout and enabled OR for the interrupt line.
    always_comb begin
        status          = '0;
        status[IRQ_TXR] = tx_rdy;
        status[IRQ_RXR] = rx_rdy;
        status[IRQ_ERR0 +: NUM_ERR] = err_q;
        irq             = |(status & ie);
    end
endmodule

// File: rtl/i2c_ctl_rxport.sv
// Module: i2c_ctl_rxport
// Receive data port: a read pops the FIFO head when the FIFO holds data;
// on an empty FIFO it returns the last popped byte and pops nothing.
module i2c_ctl_rxport #(
    parameter int LVL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_sel,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [7:0]       rx_head,
    output logic             rx_pop,
    output logic [7:0]       rx_byte
);
    logic [7:0] last_q;

    // Pop request and the byte returned to the read mux.
    always_comb begin
        rx_pop  = rd_sel && (rx_level != '0);
        rx_byte = rx_pop ? rx_head : last_q;
    end

    // Remember the most recently popped byte.
    always_ff @(posedge clk) begin
        if (!rst_n)
            last_q <= '0;
        else if (rx_pop)
            last_q <= rx_head;
    end
endmodule

// File: rtl/i2c_ctl_regs.sv
// Module: i2c_ctl_regs
// Register block for an I2C master engine: decode, configuration, status
// and interrupt, command push and receive pop, registered read data.
// Assumes a read and a write never share a cycle.
module i2c_ctl_regs
    import i2c_ctl_pkg::*;
#(
    parameter int FIFO_DEPTH = 4,
    parameter int CNT_W      = 16,
    parameter int ADDR_W     = 6,
    localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_en,
    input  logic              bus_rd_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [LVL_W-1:0]  cmd_level,
    input  logic [LVL_W-1:0]  rx_level,
    input  logic [7:0]        rx_head,
    input  logic              core_busy,
    input  logic              evt_nack,
    input  logic              evt_arb_lost,
    input  logic              evt_rx_ovf,
    output logic              cmd_push,
    output logic [CMD_W-1:0]  cmd_word,
    output logic              rx_pop,
    output logic              ctl_enable,
    output logic              ctl_fast,
    output logic [CNT_W-1:0]  scl_low,
    output logic [CNT_W-1:0]  scl_high,
    output logic [CNT_W-1:0]  sda_hold,
    output logic              irq
);
    logic [NUM_REGS-1:0]          wr_sel;
    logic [NUM_REGS-1:0]          rd_sel;
    ctl_t                         ctl_q;
    logic [IRQ_W-1:0]             ie_vec;
    logic [IRQ_W-1:0]             status_vec;
    logic [NUM_TIM-1:0][CNT_W-1:0] tim_q;
    logic [7:0]                   rx_byte;
    logic [NUM_REGS-1:0][31:0]    rd_word;
    logic [31:0]                  rdata_d;
    logic                         unused_wdata;

    assign unused_wdata = ^bus_wdata[31:CMD_W];

    i2c_ctl_decode #(.ADDR_W(ADDR_W), .NREG(NUM_REGS)) u_dec (
        .addr   (bus_addr),
        .wr     (bus_wr_en),
        .rd     (bus_rd_en),
        .wr_sel (wr_sel),
        .rd_sel (rd_sel)
    );

    i2c_ctl_cfg #(.CNT_W(CNT_W), .NREG(NUM_REGS)) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_sel (wr_sel),
        .wdata  (bus_wdata),
        .ctl_q  (ctl_q),
        .ie_q   (ie_vec),
        .tim_q  (tim_q)
    );

    i2c_ctl_irq #(.LVL_W(LVL_W)) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_thr   (ctl_q.cmd_thr),
        .rx_thr    (ctl_q.rx_thr),
        .cmd_level (cmd_level),
        .rx_level  (rx_level),
        .evt       ({evt_rx_ovf, evt_arb_lost, evt_nack}),
        .clr_wr    (wr_sel[IDX_IS]),
        .clr_mask  (bus_wdata[IRQ_W-1:0]),
        .ie        (ie_vec),
        .status    (status_vec),
        .irq       (irq)
    );

    i2c_ctl_rxport #(.LVL_W(LVL_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_sel   (rd_sel[IDX_RXD]),
        .rx_level (rx_level),
        .rx_head  (rx_head),
        .rx_pop   (rx_pop),
        .rx_byte  (rx_byte)
    );

    // Command push passes straight to the engine's FIFO.
    always_comb begin
        cmd_push = wr_sel[IDX_CMD];
        cmd_word = bus_wdata[CMD_W-1:0];
    end

    // Configuration outputs toward the engine.
    always_comb begin
        ctl_enable = ctl_q.en;
        ctl_fast   = ctl_q.fast;
        scl_low    = tim_q[0];
        scl_high   = tim_q[1];
        sda_hold   = tim_q[2];
    end

    // Read value of every register, zero-extended.
    always_comb begin
        rd_word          = '0;
        rd_word[IDX_RXD] = 32'(rx_byte);
        rd_word[IDX_CTL] = 32'(ctl_q);
        rd_word[IDX_IE]  = 32'(ie_vec);
        rd_word[IDX_IS]  = 32'(status_vec);
        rd_word[IDX_ST]  = 32'(core_busy);
        rd_word[IDX_CLV] = 32'(cmd_level);
        rd_word[IDX_RLV] = 32'(rx_level);
        for (int t = 0; t < NUM_TIM; t++)
            rd_word[IDX_TIM0+t] = 32'(tim_q[t]);
    end

    // One-hot AND-OR read mux; no select gives 0.
    always_comb begin
        rdata_d = '0;
        for (int i = 0; i < NUM_REGS; i++)
            rdata_d = rdata_d | (rd_sel[i] ? rd_word[i] : 32'd0);
    end

    // Read data register, loaded only on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_rdata <= '0;
        else if (bus_rd_en)
            bus_rdata <= rdata_d;
    end
endmodule

// File: rtl/i2c_ctl_regs_chk.sv
// Module: i2c_ctl_regs_chk
// Property checker bound to i2c_ctl_regs. Observes ports plus the status
// and enable vectors that separate submodules drive.
module i2c_ctl_regs_chk
    import i2c_ctl_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LVL_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr_en,
    input logic              bus_rd_en,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic [LVL_W-1:0]  rx_level,
    input logic              evt_nack,
    input logic              cmd_push,
    input logic              rx_pop,
    input logic              irq,
    input logic [IRQ_W-1:0]  status_vec,
    input logic [IRQ_W-1:0]  ie_vec
);
    localparam int IDXW = ADDR_W - 2;

    logic is_clr_nack;
    assign is_clr_nack = bus_wr_en && (bus_addr[ADDR_W-1:2] == IDXW'(IDX_IS))
                         && bus_wdata[IRQ_ERR0];

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (irq == 1'b0 && bus_rdata == 32'd0));

    p_nack_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        evt_nack |=> status_vec[IRQ_ERR0]);

    p_nack_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (status_vec[IRQ_ERR0] && !is_clr_nack) |=> status_vec[IRQ_ERR0]);

    p_irq_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ie_vec == '0) |-> !irq);

    p_push_on_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_push |-> bus_wr_en);

    p_no_pop_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pop |-> (bus_rd_en && rx_level != '0));

    p_rdata_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_en |=> $stable(bus_rdata));
endmodule

bind i2c_ctl_regs i2c_ctl_regs_chk #(.ADDR_W(ADDR_W), .LVL_W(LVL_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr_en  (bus_wr_en),
    .bus_rd_en  (bus_rd_en),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .rx_level   (rx_level),
    .evt_nack   (evt_nack),
    .cmd_push   (cmd_push),
    .rx_pop     (rx_pop),
    .irq        (irq),
    .status_vec (status_vec),
    .ie_vec     (ie_vec)
);

// File: tb/i2c_ctl_regs_bench.sv
// Bench for i2c_ctl_regs: sweeps thresholds, levels and interrupt masks
// at the default configuration and computes every expected value itself.
module i2c_ctl_regs_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 4;
    localparam int CW         = 16;
    localparam int AW         = 6;
    localparam int LW         = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr_en = 1'b0;
    logic          bus_rd_en = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [LW-1:0] cmd_level = '0;
    logic [LW-1:0] rx_level = '0;
    logic [7:0]    rx_head = '0;
    logic          core_busy = 1'b0;
    logic          evt_nack = 1'b0;
    logic          evt_arb_lost = 1'b0;
    logic          evt_rx_ovf = 1'b0;
    logic          cmd_push;
    logic [9:0]    cmd_word;
    logic          rx_pop;
    logic          ctl_enable;
    logic          ctl_fast;
    logic [CW-1:0] scl_low;
    logic [CW-1:0] scl_high;
    logic [CW-1:0] sda_hold;
    logic          irq;

    int            n_tests = 0;
    int            n_fail  = 0;
    int            cycles  = 0;
    logic [31:0]   rd_val;
    logic          pop_seen;

    i2c_ctl_regs #(.FIFO_DEPTH(DEPTH), .CNT_W(CW), .ADDR_W(AW)) u_i2c_ctl_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cmd_level(cmd_level), .rx_level(rx_level), .rx_head(rx_head),
        .core_busy(core_busy), .evt_nack(evt_nack), .evt_arb_lost(evt_arb_lost),
        .evt_rx_ovf(evt_rx_ovf), .cmd_push(cmd_push), .cmd_word(cmd_word),
        .rx_pop(rx_pop), .ctl_enable(ctl_enable), .ctl_fast(ctl_fast),
        .scl_low(scl_low), .scl_high(scl_high), .sda_hold(sda_hold), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: cycles %0d expected below 100000", cycles);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests = n_tests + 1;
        if (act !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr_en = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [AW-1:0] a);
        @(negedge clk);
        bus_rd_en = 1'b1; bus_addr = a;
        #1 pop_seen = rx_pop;
        @(negedge clk);
        bus_rd_en = 1'b0;
        rd_val = bus_rdata;
    endtask

    task automatic pulse(input logic [2:0] m);
        @(negedge clk);
        evt_nack = m[0]; evt_arb_lost = m[1]; evt_rx_ovf = m[2];
        @(negedge clk);
        evt_nack = 1'b0; evt_arb_lost = 1'b0; evt_rx_ovf = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 irq", 32'(irq), 0);
        chk("R1 rdata", bus_rdata, 0);
        chk("R1 timing", {scl_low, scl_high} | 32'(sda_hold), 0);
        rd(6'h08); chk("R1 ctl", rd_val, 0);
        rd(6'h0C); chk("R1 ie", rd_val, 0);
        rd(6'h10); chk("R1 sticky", rd_val & 32'h1C, 0);

        // R9: empty read before any pop returns 0 without popping
        rx_level = 0; rx_head = 8'h77;
        rd(6'h04); chk("R9 empty pop", 32'(pop_seen), 0); chk("R9 empty data", rd_val, 0);
        rx_level = 2; rx_head = 8'hA5;
        rd(6'h04); chk("R9 pop", 32'(pop_seen), 1); chk("R9 data", rd_val, 32'hA5);
        rx_level = 0; rx_head = 8'h3C;
        rd(6'h04); chk("R9 empty pop2", 32'(pop_seen), 0); chk("R9 last", rd_val, 32'hA5);

        // R2: control word fields
        wr(6'h08, 32'hFFFF_FFFF);
        rd(6'h08); chk("R2 readback", rd_val, 32'h3F);
        chk("R2 en", 32'(ctl_enable), 1); chk("R2 fast", 32'(ctl_fast), 1);
        wr(6'h08, 32'h2);
        chk("R2 en off", 32'(ctl_enable), 0); chk("R2 fast on", 32'(ctl_fast), 1);

        // R3 and R4: threshold sweeps over every code and level
        for (int t = 0; t < 4; t++) begin
            wr(6'h08, 32'(t << 2) | 32'(t << 4));
            for (int l = 0; l <= DEPTH; l++) begin
                cmd_level = LW'(l); rx_level = LW'(l);
                rd(6'h10);
                chk("R3 tx ready", 32'(rd_val[0]), 32'(l <= t + 1));
                chk("R4 rx ready", 32'(rd_val[1]), 32'(l >= t + 1));
            end
        end
        rx_level = 0;

        // R7 and R5: every enable mask against every status pattern
        wr(6'h08, 32'h0);
        for (int s = 0; s < 8; s++) begin
            for (int r = 0; r < 4; r++) begin
                wr(6'h10, 32'h1C);
                pulse(3'(s));
                cmd_level = (r & 1) != 0 ? LW'(0) : LW'(4);
                rx_level  = (r & 2) != 0 ? LW'(1) : LW'(0);
                rd(6'h10); chk("R5 status", rd_val, 32'((s << 2) | r));
                for (int m = 0; m < 32; m++) begin
                    wr(6'h0C, 32'(m));
                    chk("R7 irq", 32'(irq), 32'((m & ((s << 2) | r)) != 0));
                end
            end
        end
        rd(6'h0C); chk("R7 ie readback", rd_val, 32'd31);
        wr(6'h0C, 32'hFFFF_FFE0); rd(6'h0C); chk("R7 ie upper", rd_val, 0);

        // R6: write-1-clear, write-0 keep, set wins, ready bits untouched
        cmd_level = 0; rx_level = 1;
        pulse(3'b111);
        wr(6'h10, 32'h0); rd(6'h10); chk("R6 write0", rd_val, 32'h1F);
        wr(6'h10, 32'h04); rd(6'h10); chk("R6 clr nack", rd_val, 32'h1B);
        wr(6'h10, 32'h03); rd(6'h10); chk("R6 ready kept", rd_val, 32'h1B);
        @(negedge clk);
        bus_wr_en = 1'b1; bus_addr = 6'h10; bus_wdata = 32'h08; evt_arb_lost = 1'b1;
        @(negedge clk);
        bus_wr_en = 1'b0; evt_arb_lost = 1'b0;
        rd(6'h10); chk("R6 set wins", rd_val, 32'h1B);
        wr(6'h10, 32'h18); rd(6'h10); chk("R6 clr two", rd_val, 32'h03);
        rx_level = 0;

        // R8: command push and word
        @(negedge clk);
        bus_wr_en = 1'b1; bus_addr = 6'h00; bus_wdata = 32'hFFFF_FE5A;
        #1 chk("R8 push", 32'(cmd_push), 1); chk("R8 word", 32'(cmd_word), 32'h25A);
        @(negedge clk);
        bus_wr_en = 1'b0;
        #1 chk("R8 no push", 32'(cmd_push), 0);

        // R10: read-only views
        core_busy = 1; cmd_level = 3; rx_level = 4;
        rd(6'h14); chk("R10 busy", rd_val, 1);
        rd(6'h18); chk("R10 cmd lvl", rd_val, 3);
        rd(6'h1C); chk("R10 rx lvl", rd_val, 4);
        rx_level = 0;

        // R11: timing counts
        wr(6'h20, 32'hFFFF_1234); wr(6'h24, 32'h0000_BEEF); wr(6'h28, 32'h55);
        chk("R11 low", 32'(scl_low), 32'h1234);
        chk("R11 high", 32'(scl_high), 32'hBEEF);
        chk("R11 hold", 32'(sda_hold), 32'h55);
        rd(6'h20); chk("R11 low rb", rd_val, 32'h1234);
        rd(6'h28); chk("R11 hold rb", rd_val, 32'h55);

        // R12: unmapped, read-only writes, rdata hold
        rd(6'h2C); chk("R12 unmapped", rd_val, 0);
        wr(6'h2C, 32'hFFFF_FFFF); wr(6'h14, 32'h0); wr(6'h18, 32'h0);
        rd(6'h14); chk("R12 ro status", rd_val, 1);
        rd(6'h08); chk("R12 ctl intact", rd_val, 0);
        rd(6'h24);
        repeat (3) @(negedge clk);
        chk("R12 hold", bus_rdata, 32'hBEEF);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule